// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a byte-wide register file of 128 entries. Each transaction is framed by an active-low select. The first byte is a command, the second byte is a start address, and every byte after that is data. Data bytes move through consecutive addresses, so one command and one address can cover the whole map in a single burst. The address counter rolls over from the top address to zero.

The SPI pins are brought into the system clock through synchronisers. The system clock runs at least four times faster than SCLK. The bus works in mode 0: both sides sample on the rising SCLK edge and change data on the falling edge, most significant bit first. The register file itself sits outside the block, behind a synchronous port. The block also keeps a registered copy of bit 0 of register 1 and drives it out as the switch-enable signal.

Top module: `spi_regport`

## Requirements
- R1: During and after a synchronous reset, reg_we, reg_rd, spi_miso and sw_enable are all 0.
- R2: Command byte 0x02, then an address byte, then one data byte produces exactly one reg_we pulse. That pulse carries that address (low 7 bits of the address byte) and that data byte.
- R3: Command byte 0x03, then an address byte, shifts the register's byte out on spi_miso during the next 8 SCLK cycles. Each bit is changed after a falling edge and is valid at the rising edge, MSB first. The register port read data is valid one clock after reg_rd.
- R4: In a write burst, each further data byte goes to the address one above the previous byte's address.
- R5: In a read burst, the byte at the next address follows the previous byte on spi_miso with no gap.
- R6: The address after 127 is 0, for both read and write bursts.
- R7: With any command byte other than 0x02 or 0x03, the rest of the transaction causes no reg_we, no reg_rd and keeps spi_miso at 0, until select goes high.
- R8: Driving select high ends the transaction and drops any partial byte. The next low period starts again with a command byte.
- R9: sw_enable takes bit 0 of each byte written to address 1 and holds it otherwise.
- R10: While select is high, spi_miso is 0 and no register access is issued.
- R11: reg_we and reg_rd are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when idle |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe, one cycle |
| reg_rd | output | 1 | Register file read strobe, one cycle |
| reg_rdata | input | 8 | Register file read data, valid one cycle after reg_rd |
| sw_enable | output | 1 | Switch enable, bit 0 of register 1 |

## Verification
The assertions check four things on every cycle. While deselected, the block issues no register access and keeps spi_miso low. Reads and writes are exclusive. Register accesses only follow an SCLK rising edge. The enable output changes only on a write to address 1 and then takes that bit.

Some behaviours need the bench's scenarios instead. These are the byte ordering on the wire, address stepping and rollover across long bursts, rejection of unknown commands, and recovery after a deselect in the middle of a byte. The bench shows them by comparing full write and read bursts against an arithmetically generated pattern.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_rd,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);

  phase_t            phase;
  logic              is_read;
  logic              sclk_d;
  logic              rd_pend;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic [ADDR_W-1:0] addr_q;

  logic              rise, fall, last_bit;
  logic [DATA_W-1:0] byte_in;
  logic [DATA_W-1:0] tx_src;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign last_bit = (bit_cnt == CNT_W'(DATA_W-1));
  assign byte_in  = {rx_sh[DATA_W-2:0], mosi_s};
  // Fresh read data bypasses the shifter when a falling edge coincides with it.
  assign tx_src   = rd_pend ? reg_rdata : tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      is_read   <= 1'b0;
      sclk_d    <= 1'b0;
      rd_pend   <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      addr_q    <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_rd    <= 1'b0;
      miso      <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_rd  <= 1'b0;
      sclk_d  <= sclk_s;
      rd_pend <= reg_rd;
      if (rd_pend) tx_sh <= reg_rdata;

      if (cs_n_s) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh   <= byte_in;
          bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
          if (last_bit) begin
            case (phase)
              PH_CMD: begin
                if (byte_in == DATA_W'(OP_READ)) begin
                  is_read <= 1'b1;
                  phase   <= PH_ADDR;
                end else if (byte_in == DATA_W'(OP_WRITE)) begin
                  is_read <= 1'b0;
                  phase   <= PH_ADDR;
                end else begin
                  phase   <= PH_SKIP;
                end
              end
              PH_ADDR: begin
                addr_q <= byte_in[ADDR_W-1:0];
                phase  <= PH_DATA;
                if (is_read) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= byte_in[ADDR_W-1:0];
                end
              end
              PH_DATA: begin
                addr_q <= addr_q + 1'b1;
                if (is_read) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= addr_q + 1'b1;
                end else begin
                  reg_we    <= 1'b1;
                  reg_addr  <= addr_q;
                  reg_wdata <= byte_in;
                end
              end
              default: ;
            endcase
          end
        end
        if (fall) begin
          if (phase == PH_DATA && is_read) begin
            miso  <= tx_src[DATA_W-1];
            tx_sh <= {tx_src[DATA_W-2:0], 1'b0};
          end else begin
            miso  <= 1'b0;
          end
        end
      end
    end
  end

  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (!reg_we && !reg_rd)); // R10
  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso); // R10
  AST_RD_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_rd)); // R11
  AST_ACCESS_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_rd) |-> $past(sclk_s && !sclk_d)); // R2
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ENABLE_ADDR = 1,
  parameter int ENABLE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sw_enable
);
  localparam int         N_PINS  = 3;
  localparam logic [2:0] PIN_RST = 3'b010; // select idles high

  logic [N_PINS-1:0] pin_raw, pin_s;
  assign pin_raw = {spi_mosi, spi_cs_n, spi_sclk};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    spi_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(pin_raw[g]), .q(pin_s[g])
    );
  end

  spi_regport_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst),
    .sclk_s(pin_s[0]), .cs_n_s(pin_s[1]), .mosi_s(pin_s[2]),
    .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rd(reg_rd), .miso(spi_miso)
  );

  logic en_hit;
  assign en_hit = reg_we && (reg_addr == ADDR_W'(ENABLE_ADDR));

  always_ff @(posedge clk) begin
    if (rst)         sw_enable <= 1'b0;
    else if (en_hit) sw_enable <= reg_wdata[ENABLE_BIT];
  end

  AST_ENABLE_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    en_hit |=> (sw_enable == $past(reg_wdata[ENABLE_BIT]))); // R9
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en_hit |=> $stable(sw_enable)); // R9
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, we, rd, sw_en;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;

  always #2 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rd(rd), .reg_rdata(rdata), .sw_enable(sw_en)
  );

  // register file model: synchronous write and read
  logic [7:0] mem [0:127];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
      rdata <= 8'h00;
    end else begin
      if (we) mem[addr] <= wdata;
      if (rd) rdata <= mem[addr];
    end
  end

  int wr_cnt, rd_cnt, miso_hi, both_cnt;
  always @(posedge clk) begin
    if (we) wr_cnt++;
    if (rd) rd_cnt++;
    if (miso) miso_hi++;
    if (we && rd) both_cnt++;
  end

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] exp_mem [0:127];
  logic [7:0] txb [0:255];
  logic [7:0] rxb [0:255];

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_cnt = 0; rd_cnt = 0; miso_hi = 0; both_cnt = 0;
  endtask

  task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xact(input logic [7:0] cmd, input logic [7:0] a, input int n);
    logic [7:0] junk;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    shift_byte(cmd, junk, 8);
    shift_byte(a, junk, 8);
    for (int k = 0; k < n; k++) shift_byte(txb[k], rxb[k], 8);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 12) & 255);
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    clear_mon();
    repeat (6) @(negedge clk);
    check("R1 reg_we", int'(we), 0);
    check("R1 reg_rd", int'(rd), 0);
    check("R1 miso", int'(miso), 0);
    check("R1 sw_enable", int'(sw_en), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon();

    // full-map write burst starting at 5, rolls over past 127 (R4, R6)
    for (int k = 0; k < 128; k++) begin
      txb[k] = pat((5 + k) % 128);
      exp_mem[(5 + k) % 128] = txb[k];
    end
    xact(8'h02, 8'd5, 128);
    check("R4 write count", wr_cnt, 128);
    check("R2 miso quiet during write", miso_hi, 0);
    check("R9 enable from burst", int'(sw_en), int'(exp_mem[1][0]));
    for (int a = 0; a < 128; a++)
      check((a < 5) ? "R6 wrapped write" : "R4 burst write", int'(mem[a]), int'(exp_mem[a]));

    // read burst from 120 covering more than one pass (R3, R5, R6)
    clear_mon();
    for (int k = 0; k < 130; k++) txb[k] = 8'hFF;
    xact(8'h03, 8'd120, 130);
    check("R3 read count", rd_cnt, 131);
    check("R11 exclusive strobes", both_cnt, 0);
    for (int k = 0; k < 130; k++)
      check(((120 + k) >= 128) ? "R6 wrapped read" : "R5 burst read",
            int'(rxb[k]), int'(exp_mem[(120 + k) % 128]));

    // single write to the enable register, then read it back (R2, R3, R9)
    txb[0] = 8'hFE; exp_mem[1] = 8'hFE;
    xact(8'h02, 8'd1, 1);
    check("R9 enable cleared", int'(sw_en), 0);
    txb[0] = 8'h01; exp_mem[1] = 8'h01;
    xact(8'h02, 8'd1, 1);
    check("R9 enable set", int'(sw_en), 1);
    xact(8'h03, 8'd1, 1);
    check("R3 single read", int'(rxb[0]), 8'h01);

    // unknown command: no access, miso quiet (R7)
    clear_mon();
    txb[0] = 8'h00; txb[1] = 8'hAA; txb[2] = 8'h55;
    xact(8'hA5, 8'd1, 3);
    check("R7 no write", wr_cnt, 0);
    check("R7 no read", rd_cnt, 0);
    check("R7 miso low", miso_hi, 0);
    check("R7 enable kept", int'(sw_en), 1);
    for (int k = 0; k < 3; k++) check("R7 rx zero", int'(rxb[k]), 0);
    check("R7 register kept", int'(mem[1]), 8'h01);

    // deselect in the middle of a byte, then a normal write (R8)
    begin
      logic [7:0] junk;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      shift_byte(8'h03, junk, 5);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
    end
    txb[0] = 8'h3C; exp_mem[9] = 8'h3C;
    xact(8'h02, 8'd9, 1);
    xact(8'h03, 8'd9, 2);
    check("R8 write after abort", int'(rxb[0]), 8'h3C);
    check("R8 neighbour untouched", int'(rxb[1]), int'(exp_mem[10]));

    // two-byte write across the top address (R6)
    txb[0] = 8'h11; txb[1] = 8'h22; exp_mem[127] = 8'h11; exp_mem[0] = 8'h22;
    xact(8'h02, 8'd127, 2);
    xact(8'h03, 8'd127, 2);
    check("R6 top byte", int'(rxb[0]), 8'h11);
    check("R6 wrapped byte", int'(rxb[1]), 8'h22);

    // deselected: miso low and no access while the clock toggles (R10)
    clear_mon();
    begin
      logic [7:0] junk;
      shift_byte(8'hFF, junk, 8);
    end
    repeat (4) @(negedge clk);
    check("R10 no access", wr_cnt + rd_cnt, 0);
    check("R10 miso low", miso_hi, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule